// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

A 32-pin general-purpose I/O bank driven through a simple word-wide register port. One register window holds the output data latch and the per-pin direction control. The other window holds the interrupt unit: an enable mask, three sense-type masks and a sticky status register. Output pins drive the data latch wherever the direction bit is set. Input pins are sampled through a two-flop synchroniser. The synchronised samples feed a per-pin detector, which can sense a falling edge, a rising edge, both edges, a low level or a high level.

Each pin's sense setting decodes into one of five named modes:

- **FALL**: type1=0, type2=0, type0=0.
- **RISE**: type1=0, type2=0, type0=1.
- **BOTH**: type1=0, type2=1, with type0 ignored.
- **LOW**: type1=1, type0=0.
- **HIGH**: type1=1, type0=1.

A detected event sets the pin's status bit, whatever the enable mask holds. Software clears a status bit by writing a one to it. The single interrupt output is raised while any status bit is set together with its enable bit. Reads are registered: a read strobe loads the read data register on the next clock edge, and the value then holds until the next read.

Top module: `gpio_bank`

## Requirements
- R1: After reset all registers are zero. pin_oe, pin_out, bus_rdata and irq_out are 0, and every pin senses FALL.
- R2: In window 0 (bus_win=0), word address 0 is the data latch and word address 1 is the direction mask. A written value appears on pin_out or pin_oe after the write edge, where a 1 bit in the direction mask means an output. A read strobe loads bus_rdata with the addressed register on the same clock edge.
- R3: Reading window 0 address 0 returns the data latch for output bits. For input bits it returns the pin value after two clock stages of synchronisation.
- R4: In window 1, word address 0 is the enable mask, 1 is type0, 2 is type1, 3 is type2 and 4 is status, each with bit n for pin n. The first four read back as written.
- R5: In FALL mode, a 1-to-0 change on pin n sets status bit n on the third clock edge after the change is presented.
- R6: In RISE mode, a 0-to-1 change sets the status bit, and a 1-to-0 change does not.
- R7: In BOTH mode, either change sets the status bit, whatever type0 holds.
- R8: In LOW or HIGH mode, the status bit is set on every cycle in which the synchronised pin is at the active level (0 for LOW, 1 for HIGH). A clear therefore has no lasting effect while the level persists.
- R9: Writing status (window 1 address 4) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R10: When a detection event and a clear of the same status bit fall on the same clock edge, the bit ends up set.
- R11: irq_out is 1 exactly when some status bit and its enable bit are both 1. Status bits are recorded even while disabled.
- R12: Reads of unmapped addresses (window 0 addresses 2 to 7, window 1 addresses 5 to 7) return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_win | input | 1 | Window select: 0 pin registers, 1 interrupt registers |
| bus_addr | input | 3 | Word address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pin input levels |
| pin_out | output | 32 | Pin output levels |
| pin_oe | output | 32 | Pin output enables |
| irq_out | output | 1 | Aggregate interrupt |

## Verification
The pins are set up as six inputs, one for each sense mode, plus BOTH a second time with type0 set. Every pin then sees a rise and a fall, so a wrong mode decode shows up as a stray or a missing status bit. Level pins are cleared while still active and again after going inactive, which separates sticky level re-arming from edge latching. A clear is placed on exactly the edge where a falling event lands, which shows whether set beats clear. The enable mask is toggled around a pending bit, which separates recording from forwarding.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam logic WIN_PINS = 1'b0;
    localparam logic WIN_INTR = 1'b1;

    localparam int A_DATA   = 0;
    localparam int A_DIR    = 1;
    localparam int A_ENABLE = 0;
    localparam int A_TYPE0  = 1;
    localparam int A_TYPE1  = 2;
    localparam int A_TYPE2  = 3;
    localparam int A_STATUS = 4;

    typedef enum logic [2:0] {
        SNS_FALL = 3'd0,
        SNS_RISE = 3'd1,
        SNS_BOTH = 3'd2,
        SNS_LOW  = 3'd3,
        SNS_HIGH = 3'd4
    } sense_e;

    // Level selection dominates; the both-edge bit only matters for edges.
    function automatic sense_e decode_sense(input logic t0, input logic t1, input logic t2);
        if (t1)      return t0 ? SNS_HIGH : SNS_LOW;
        else if (t2) return SNS_BOTH;
        else         return t0 ? SNS_RISE : SNS_FALL;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    // R3
    sync_two_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stage2_q == $past(stage1_q)));

endmodule

// File: rtl/gpio_sense.sv
module gpio_sense
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sample,
    input  logic [WIDTH-1:0] type0,
    input  logic [WIDTH-1:0] type1,
    input  logic [WIDTH-1:0] type2,
    output logic [WIDTH-1:0] event_out
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sample;
    end

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            unique case (decode_sense(type0[i], type1[i], type2[i]))
                SNS_FALL: event_out[i] = prev_q[i] & ~sample[i];
                SNS_RISE: event_out[i] = ~prev_q[i] & sample[i];
                SNS_BOTH: event_out[i] = prev_q[i] ^ sample[i];
                SNS_LOW:  event_out[i] = ~sample[i];
                SNS_HIGH: event_out[i] = sample[i];
                default:  event_out[i] = 1'b0;
            endcase
        end
    end

    // R6
    edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((event_out & ~type1 & ~(sample ^ prev_q)) == '0));

    // R8
    level_matches_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((event_out & type1 & (sample ^ type0)) == '0));

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_evt,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] status
);
    logic [WIDTH-1:0] status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | set_evt;
    end

    assign status = status_q;

    // R9
    clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_mask & ~set_evt)) |=> ((status_q & $past(clr_mask & ~set_evt)) == '0));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_evt) |=> ((status_q & $past(set_evt)) == $past(set_evt)));

    // R5
    rise_only_from_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_evt)) == '0));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int PINS   = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_win,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq_out
);
    localparam logic [ADDR_W-1:0] AD_DATA   = ADDR_W'(A_DATA);
    localparam logic [ADDR_W-1:0] AD_DIR    = ADDR_W'(A_DIR);
    localparam logic [ADDR_W-1:0] AD_ENABLE = ADDR_W'(A_ENABLE);
    localparam logic [ADDR_W-1:0] AD_TYPE0  = ADDR_W'(A_TYPE0);
    localparam logic [ADDR_W-1:0] AD_TYPE1  = ADDR_W'(A_TYPE1);
    localparam logic [ADDR_W-1:0] AD_TYPE2  = ADDR_W'(A_TYPE2);
    localparam logic [ADDR_W-1:0] AD_STATUS = ADDR_W'(A_STATUS);

    logic [PINS-1:0] data_q, dir_q, en_q, t0_q, t1_q, t2_q;
    logic [PINS-1:0] smp, evt, status, clr_mask, rd_mux;
    logic wr_data, wr_dir, wr_en, wr_t0, wr_t1, wr_t2, wr_st;

    always_comb begin
        wr_data = bus_wr && bus_win == WIN_PINS && bus_addr == AD_DATA;
        wr_dir  = bus_wr && bus_win == WIN_PINS && bus_addr == AD_DIR;
        wr_en   = bus_wr && bus_win == WIN_INTR && bus_addr == AD_ENABLE;
        wr_t0   = bus_wr && bus_win == WIN_INTR && bus_addr == AD_TYPE0;
        wr_t1   = bus_wr && bus_win == WIN_INTR && bus_addr == AD_TYPE1;
        wr_t2   = bus_wr && bus_win == WIN_INTR && bus_addr == AD_TYPE2;
        wr_st   = bus_wr && bus_win == WIN_INTR && bus_addr == AD_STATUS;
        clr_mask = wr_st ? bus_wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            en_q   <= '0;
            t0_q   <= '0;
            t1_q   <= '0;
            t2_q   <= '0;
        end else begin
            if (wr_data) data_q <= bus_wdata;
            if (wr_dir)  dir_q  <= bus_wdata;
            if (wr_en)   en_q   <= bus_wdata;
            if (wr_t0)   t0_q   <= bus_wdata;
            if (wr_t1)   t1_q   <= bus_wdata;
            if (wr_t2)   t2_q   <= bus_wdata;
        end
    end

    gpio_sync #(.WIDTH(PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(pin_in), .sync_out(smp)
    );

    gpio_sense #(.WIDTH(PINS)) u_sense (
        .clk(clk), .rst_n(rst_n), .sample(smp),
        .type0(t0_q), .type1(t1_q), .type2(t2_q), .event_out(evt)
    );

    gpio_irq_status #(.WIDTH(PINS)) u_status (
        .clk(clk), .rst_n(rst_n), .set_evt(evt), .clr_mask(clr_mask), .status(status)
    );

    always_comb begin
        rd_mux = '0;
        if (bus_win == WIN_PINS) begin
            unique case (bus_addr)
                AD_DATA: rd_mux = (data_q & dir_q) | (smp & ~dir_q);
                AD_DIR:  rd_mux = dir_q;
                default: rd_mux = '0;
            endcase
        end else begin
            unique case (bus_addr)
                AD_ENABLE: rd_mux = en_q;
                AD_TYPE0:  rd_mux = t0_q;
                AD_TYPE1:  rd_mux = t1_q;
                AD_TYPE2:  rd_mux = t2_q;
                AD_STATUS: rd_mux = status;
                default:   rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign pin_out = data_q;
    assign pin_oe  = dir_q;
    assign irq_out = |(status & en_q);

    // R2
    oe_follows_dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (pin_oe == $past(bus_wdata)));

    // R11
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|en_q));

endmodule

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_win = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, pin_in = '0;
    logic [31:0] bus_rdata, pin_out, pin_oe;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    gpio_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_win(bus_win), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // Behavioural reference model
    logic [31:0] m_s1, m_s2, m_prev, m_data, m_dir, m_en, m_t0, m_t1, m_t2, m_st, m_rd;

    always @(posedge clk or negedge rst_n) begin
        logic [31:0] ev, rv;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_data = 0; m_dir = 0; m_en = 0;
            m_t0 = 0; m_t1 = 0; m_t2 = 0; m_st = 0; m_rd = 0;
        end else begin
            for (int i = 0; i < 32; i++) begin
                if (m_t1[i])      ev[i] = (m_s2[i] == m_t0[i]);
                else if (m_t2[i]) ev[i] = (m_s2[i] != m_prev[i]);
                else if (m_t0[i]) ev[i] = m_s2[i] & ~m_prev[i];
                else              ev[i] = ~m_s2[i] & m_prev[i];
            end
            rv = 0;
            if (!bus_win) begin
                if (bus_addr == 0) rv = (m_data & m_dir) | (m_s2 & ~m_dir);
                if (bus_addr == 1) rv = m_dir;
            end else begin
                case (bus_addr)
                    0: rv = m_en;
                    1: rv = m_t0;
                    2: rv = m_t1;
                    3: rv = m_t2;
                    4: rv = m_st;
                    default: rv = 0;
                endcase
            end
            if (bus_rd) m_rd = rv;
            if (bus_wr && bus_win && bus_addr == 4) m_st = m_st & ~bus_wdata;
            m_st = m_st | ev;
            if (bus_wr && !bus_win && bus_addr == 0) m_data = bus_wdata;
            if (bus_wr && !bus_win && bus_addr == 1) m_dir = bus_wdata;
            if (bus_wr && bus_win && bus_addr == 0) m_en = bus_wdata;
            if (bus_wr && bus_win && bus_addr == 1) m_t0 = bus_wdata;
            if (bus_wr && bus_win && bus_addr == 2) m_t1 = bus_wdata;
            if (bus_wr && bus_win && bus_addr == 3) m_t2 = bus_wdata;
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "model pin_out", pin_out, m_data);
            chk(cur_req, "model pin_oe", pin_oe, m_dir);
            chk(cur_req, "model rdata", bus_rdata, m_rd);
            chk(cur_req, "model irq", {31'b0, irq_out}, {31'b0, |(m_st & m_en)});
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic w, input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_win = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic w, input logic [2:0] a, input logic [31:0] exp);
        bus_rd = 1'b1; bus_win = w; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(req, "read", bus_rdata, exp);
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(2);
        // R1
        chk("R1", "pin_oe", pin_oe, 0);
        chk("R1", "pin_out", pin_out, 0);
        chk("R1", "irq", {31'b0, irq_out}, 0);
        rd_chk("R1", 1, 4, 0);
        rd_chk("R1", 1, 2, 0);

        cur_req = "R2";
        wr(0, 1, 32'h0000FFFF);
        wr(0, 0, 32'hA5A51234);
        chk("R2", "pin_out", pin_out, 32'hA5A51234);
        chk("R2", "pin_oe", pin_oe, 32'h0000FFFF);
        rd_chk("R2", 0, 1, 32'h0000FFFF);

        cur_req = "R3";
        pin_in = 32'hCAFE5555;
        idle(3);
        rd_chk("R3", 0, 0, 32'hCAFE1234);

        cur_req = "R4";
        pin_in = 32'h00110000;
        wr(1, 1, 32'h002A0000);
        wr(1, 2, 32'h00300000);
        wr(1, 3, 32'h000C0000);
        idle(4);
        wr(1, 4, 32'hFFFFFFFF);
        idle(2);
        rd_chk("R4", 1, 1, 32'h002A0000);
        rd_chk("R4", 1, 2, 32'h00300000);
        rd_chk("R4", 1, 3, 32'h000C0000);
        rd_chk("R9", 1, 4, 0);

        cur_req = "R5";
        pin_in[16] = 1'b0;
        idle(4);
        rd_chk("R5", 1, 4, 32'h00010000);
        chk("R11", "irq disabled", {31'b0, irq_out}, 0);

        cur_req = "R6";
        pin_in[17] = 1'b1;
        idle(4);
        rd_chk("R6", 1, 4, 32'h00030000);

        cur_req = "R7";
        pin_in[19:18] = 2'b11;
        idle(4);
        rd_chk("R7", 1, 4, 32'h000F0000);
        wr(1, 4, 32'h000C0000);
        idle(2);
        rd_chk("R7", 1, 4, 32'h00030000);
        pin_in[19:18] = 2'b00;
        idle(4);
        rd_chk("R7", 1, 4, 32'h000F0000);

        cur_req = "R8";
        pin_in[20] = 1'b0;
        idle(4);
        wr(1, 4, 32'h00100000);
        idle(2);
        rd_chk("R8", 1, 4, 32'h001F0000);
        pin_in[21] = 1'b1;
        idle(4);
        rd_chk("R8", 1, 4, 32'h003F0000);
        pin_in[21:20] = 2'b01;
        idle(4);
        wr(1, 4, 32'h00300000);
        idle(2);
        rd_chk("R8", 1, 4, 32'h000F0000);

        cur_req = "R9";
        wr(1, 4, 32'h0);
        idle(1);
        rd_chk("R9", 1, 4, 32'h000F0000);
        wr(1, 4, 32'h000F0000);
        idle(1);
        rd_chk("R9", 1, 4, 32'h0);

        cur_req = "R11";
        wr(1, 0, 32'h00020000);
        pin_in[17] = 1'b0;
        idle(4);
        chk("R11", "irq after fall on rise pin", {31'b0, irq_out}, 0);
        pin_in[17] = 1'b1;
        idle(4);
        chk("R11", "irq enabled pending", {31'b0, irq_out}, 1);
        wr(1, 0, 32'h0);
        chk("R11", "irq masked", {31'b0, irq_out}, 0);
        wr(1, 0, 32'h00020000);
        chk("R11", "irq re-enabled", {31'b0, irq_out}, 1);
        wr(1, 4, 32'h00020000);
        chk("R11", "irq after clear", {31'b0, irq_out}, 0);

        cur_req = "R10";
        pin_in[16] = 1'b1;
        idle(4);
        wr(1, 4, 32'hFFFFFFFF);
        idle(1);
        pin_in[16] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr(1, 4, 32'h00010000);
        idle(1);
        rd_chk("R10", 1, 4, 32'h00010000);

        cur_req = "R12";
        wr(0, 5, 32'hFFFFFFFF);
        wr(0, 2, 32'hFFFFFFFF);
        wr(1, 7, 32'hFFFFFFFF);
        rd_chk("R12", 0, 5, 0);
        rd_chk("R12", 1, 6, 0);
        chk("R12", "pin_out kept", pin_out, 32'hA5A51234);
        chk("R12", "pin_oe kept", pin_oe, 32'h0000FFFF);
        rd_chk("R12", 1, 0, 32'h00020000);

        idle(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule